// File: doc/BRIEF.md
# Tagged vector-configuration lookup table

This block keeps a small table of vector-configuration entries for an instruction decoder. Each entry is bound to one architectural register number through a stored tag. It carries the vector length and the packed element width to use when an instruction names that register. Software programs the table through a narrow CSR write/read port, with one address per entry field.

Decode presents a register number, a register-file flag (integer or floating point) and the element-width code that the opcode would use on its own. The lookup port is purely combinational. It compares the register number against every valid tag, and the lowest-numbered matching entry supplies the length and the width. The port also reports a hit flag and the index of the winning entry. When no entry claims the register, the instruction falls back to scalar: the length is 1 and the opcode's own width is used.

Top module: `vcfg_lookup`

## Requirements
- R1: While `rst_n` is low and after its release, every entry is invalid, holds length 1 and width field 0, so every lookup misses.
- R2: CSR address = {entry index, field[1:0]}. Field 0 is the tag: bits [4:0] hold the register number and bit 7 is the valid bit; reads return this same layout. Field 1 is the vector length. Field 2 is the 3-bit width field. Field 3 is reserved: it reads 0 and writes to it change nothing. Reads of fields 0 to 2 return the stored value.
- R3: A length write above MAX_VL (default 64) stores MAX_VL. Other values are stored unchanged.
- R4: A CSR write on one clock edge is seen by the lookup from that edge onwards, with no further delay.
- R5: A lookup whose register number equals the tag of a valid entry gives `lk_hit`=1, `lk_idx` set to that entry and `lk_vl` set to its stored length.
- R6: Width encoding is 0=8, 1=16, 2=32, 3=64 bits. On a hit, a stored width field with bit 2 set returns its bits [1:0]. With bit 2 clear, the request's `lk_dflt_bw` is returned.
- R7: When several valid entries carry the same tag, the lowest-numbered one is returned.
- R8: On a miss, `lk_hit`=0, `lk_idx`=0, `lk_vl`=1 and `lk_bw`=`lk_dflt_bw`.
- R9: An entry whose valid bit is clear never matches, whatever its tag holds.
- R10: `lk_fp` has no effect on any output: integer and floating-point registers with the same number share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | ENT_W+2 | Entry index and field select |
| csr_wdata | input | 8 | CSR write data |
| csr_rdata | output | 8 | CSR read data for `csr_addr` |
| lk_reg | input | 5 | Register number being decoded |
| lk_fp | input | 1 | Register file of the operand (ignored for matching) |
| lk_dflt_bw | input | 2 | Width code derived from the opcode |
| lk_hit | output | 1 | An entry claims the register |
| lk_idx | output | ENT_W | Winning entry index |
| lk_vl | output | VL_W | Effective vector length |
| lk_bw | output | 2 | Effective width code |

## Verification
The bench programs two entries with the same tag. A design that scans from the wrong end would then return entry 1. It clears the valid bit of an entry that still holds a matching tag; a design that compares tags alone would keep hitting it. The bench writes lengths above the limit, which a design without saturation would wrap or truncate. It stores width fields with the explicit bit clear, which a design that passes the raw code through would return in place of the opcode default. A long random stretch then mixes writes and lookups with both register-file flags. Any pipelining or stale read would show as a mismatch in the cycle after a write.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  // CSR field selector within one entry
  typedef enum logic [1:0] {
    FLD_TAG  = 2'd0,
    FLD_VL   = 2'd1,
    FLD_BW   = 2'd2,
    FLD_RSVD = 2'd3
  } vcfg_field_e;

  localparam int unsigned TAG_W  = 5;  // 32 architectural registers
  localparam int unsigned BWF_W  = 3;  // explicit bit + 2-bit width code
  localparam int unsigned BWC_W  = 2;  // width code 8/16/32/64
endpackage

// File: rtl/vcfg_entry.sv
module vcfg_entry
  import vcfg_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  vcfg_field_e      wr_field,
  input  logic [DW-1:0]    wr_data,
  output logic             valid_q,
  output logic [TAG_W-1:0] tag_q,
  output logic [VL_W-1:0]  vl_q,
  output logic [BWF_W-1:0] bwf_q
);
  logic             valid_d;
  logic [TAG_W-1:0] tag_d;
  logic [VL_W-1:0]  vl_d;
  logic [BWF_W-1:0] bwf_d;
  logic             en_tag, en_vl, en_bw;

  assign en_tag = wr_en && (wr_field == FLD_TAG);
  assign en_vl  = wr_en && (wr_field == FLD_VL);
  assign en_bw  = wr_en && (wr_field == FLD_BW);

  always_comb begin
    valid_d = wr_data[DW-1];
    tag_d   = wr_data[TAG_W-1:0];
    bwf_d   = wr_data[BWF_W-1:0];
    if (wr_data > DW'(MAX_VL)) vl_d = VL_W'(MAX_VL);
    else                       vl_d = wr_data[VL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (en_tag) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vl_q <= VL_W'(1);
    else if (en_vl) vl_q <= vl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bwf_q <= '0;
    else if (en_bw) bwf_q <= bwf_d;
  end

  p_tag_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == FLD_TAG) |=>
      (tag_q == $past(wr_data[TAG_W-1:0]) && valid_q == $past(wr_data[DW-1])));

  p_rsvd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == FLD_RSVD) |=>
      ($stable(tag_q) && $stable(valid_q) && $stable(vl_q) && $stable(bwf_q)));

  p_vl_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= VL_W'(MAX_VL));
endmodule

// File: rtl/vcfg_match.sv
module vcfg_match
  import vcfg_pkg::*;
#(
  parameter int unsigned N     = 2,
  parameter int unsigned ENT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [ENT_W-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == key);
  end

  // scan from the top so the lowest matching entry is the last written
  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = ENT_W'(i);
    end
  end
endmodule

// File: rtl/vcfg_lookup.sv
module vcfg_lookup
  import vcfg_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 2,
  parameter int unsigned MAX_VL      = 64,
  parameter int unsigned DW          = 8,
  localparam int unsigned ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned VL_W       = $clog2(MAX_VL + 1),
  localparam int unsigned AW         = ENT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [AW-1:0]    csr_addr,
  input  logic [DW-1:0]    csr_wdata,
  output logic [DW-1:0]    csr_rdata,
  input  logic [TAG_W-1:0] lk_reg,
  input  logic             lk_fp,
  input  logic [BWC_W-1:0] lk_dflt_bw,
  output logic             lk_hit,
  output logic [ENT_W-1:0] lk_idx,
  output logic [VL_W-1:0]  lk_vl,
  output logic [BWC_W-1:0] lk_bw
);
  logic [NUM_ENTRIES-1:0]            ent_valid;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [NUM_ENTRIES-1:0][VL_W-1:0]  ent_vl;
  logic [NUM_ENTRIES-1:0][BWF_W-1:0] ent_bwf;

  logic [ENT_W-1:0] a_ent;
  vcfg_field_e      a_fld;
  logic             a_inrange;
  logic             fp_unused;

  assign a_ent     = csr_addr[AW-1:2];
  assign a_fld     = vcfg_field_e'(csr_addr[1:0]);
  assign a_inrange = (32'(a_ent) < NUM_ENTRIES);
  assign fp_unused = lk_fp;  // one entry serves both register files

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    vcfg_entry #(.DW(DW), .MAX_VL(MAX_VL), .VL_W(VL_W)) i_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (csr_we && a_inrange && (a_ent == ENT_W'(g))),
      .wr_field (a_fld),
      .wr_data  (csr_wdata),
      .valid_q  (ent_valid[g]),
      .tag_q    (ent_tag[g]),
      .vl_q     (ent_vl[g]),
      .bwf_q    (ent_bwf[g])
    );
  end

  // CSR read mux
  always_comb begin
    csr_rdata = '0;
    if (a_inrange) begin
      unique case (a_fld)
        FLD_TAG: begin
          csr_rdata[TAG_W-1:0] = ent_tag[a_ent];
          csr_rdata[DW-1]      = ent_valid[a_ent];
        end
        FLD_VL:   csr_rdata[VL_W-1:0]  = ent_vl[a_ent];
        FLD_BW:   csr_rdata[BWF_W-1:0] = ent_bwf[a_ent];
        FLD_RSVD: csr_rdata = '0;
      endcase
    end
  end

  vcfg_match #(.N(NUM_ENTRIES), .ENT_W(ENT_W)) i_match (
    .valid (ent_valid),
    .tags  (ent_tag),
    .key   (lk_reg),
    .hit   (lk_hit),
    .idx   (lk_idx)
  );

  // result select with scalar fallback
  always_comb begin
    lk_vl = VL_W'(1);
    lk_bw = lk_dflt_bw;
    if (lk_hit) begin
      lk_vl = ent_vl[lk_idx];
      if (ent_bwf[lk_idx][BWF_W-1]) lk_bw = ent_bwf[lk_idx][BWC_W-1:0];
    end
  end

  p_miss_scalar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_vl == VL_W'(1) && lk_bw == lk_dflt_bw && lk_idx == '0));

  p_hit_valid_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (ent_valid[lk_idx] && ent_tag[lk_idx] == lk_reg));

  p_vl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vl <= VL_W'(MAX_VL));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_prio
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid[g] && ent_tag[g] == lk_reg) |-> (lk_hit && lk_idx <= ENT_W'(g)));
  end
endmodule

// File: tb/test_vcfg_lookup.sv
module test_vcfg_lookup;
  localparam int CLK_P = 10;
  localparam int N     = 2;
  localparam int MAXVL = 64;
  localparam int EW    = 1;
  localparam int VW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic [EW+1:0] csr_addr = '0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic [4:0]    lk_reg = '0;
  logic          lk_fp = 1'b0;
  logic [1:0]    lk_dflt_bw = '0;
  logic          lk_hit;
  logic [EW-1:0] lk_idx;
  logic [VW-1:0] lk_vl;
  logic [1:0]    lk_bw;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  bit   m_valid [N];
  int   m_tag   [N];
  int   m_vl    [N];
  int   m_bwf   [N];

  always #(CLK_P/2) clk = ~clk;

  vcfg_lookup i_vcfg_lookup (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .lk_reg(lk_reg),
    .lk_fp(lk_fp), .lk_dflt_bw(lk_dflt_bw), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_vl(lk_vl), .lk_bw(lk_bw)
  );

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_vl[i] = 1; m_bwf[i] = 0;
    end
  endtask

  task automatic compare(string tag);
    bit e_hit = 0; int e_idx = 0; int e_vl = 1; int e_bw = int'(lk_dflt_bw);
    int e_rd = 0; int ent = int'(csr_addr) >> 2; int fld = int'(csr_addr) & 3;
    for (int i = 0; i < N; i++)
      if (!e_hit && m_valid[i] && m_tag[i] == int'(lk_reg)) begin
        e_hit = 1; e_idx = i; e_vl = m_vl[i];
        if (m_bwf[i] >= 4) e_bw = m_bwf[i] - 4;
      end
    if (ent < N) begin
      if (fld == 0) e_rd = m_tag[ent] + (m_valid[ent] ? 128 : 0);
      if (fld == 1) e_rd = m_vl[ent];
      if (fld == 2) e_rd = m_bwf[ent];
    end
    vectors++;
    if (lk_hit !== e_hit || int'(lk_idx) != e_idx) begin
      miscompares++;
      $display("FAIL %s R5/R7/R9: hit/idx %0b/%0d expected %0b/%0d", tag, lk_hit, lk_idx, e_hit, e_idx);
    end
    if (int'(lk_vl) != e_vl) begin
      miscompares++;
      $display("FAIL %s R3/R5/R8: vl %0d expected %0d", tag, lk_vl, e_vl);
    end
    if (int'(lk_bw) != e_bw) begin
      miscompares++;
      $display("FAIL %s R6/R8: bw %0d expected %0d", tag, lk_bw, e_bw);
    end
    if (int'(csr_rdata) != e_rd) begin
      miscompares++;
      $display("FAIL %s R2: rdata %0h expected %0h", tag, csr_rdata, e_rd);
    end
  endtask

  // one cycle: drive after negedge, check before posedge, update model at posedge
  task automatic cyc(string tag, bit we, int addr, int wd, int rg, int dflt, bit fp);
    @(negedge clk);
    csr_we = we; csr_addr = (EW+2)'(addr); csr_wdata = 8'(wd);
    lk_reg = 5'(rg); lk_dflt_bw = 2'(dflt); lk_fp = fp;
    #1 compare(tag);
    @(posedge clk);
    if (rst_n && we && (addr >> 2) < N) begin
      case (addr & 3)
        0: begin m_tag[addr>>2] = wd & 31; m_valid[addr>>2] = (wd >> 7) & 1; end
        1: m_vl[addr>>2] = (wd > MAXVL) ? MAXVL : wd;
        2: m_bwf[addr>>2] = wd & 7;
        default: ;
      endcase
    end
  endtask

  initial begin
    model_reset();
    // R1: reset state, writes during reset are dropped
    cyc("R1 reset", 1, 0, 8'h85, 5, 1, 0);
    cyc("R1 reset", 0, 1, 0, 0, 2, 1);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 8; a++) cyc("R1 post-reset", 0, a, 0, a, a & 3, 0);
    // R2/R4/R5/R6: program entry 0, lookup right after
    cyc("R2 tag", 1, 0, 8'h85, 5, 0, 0);
    cyc("R4 visible", 1, 1, 16, 5, 1, 0);
    cyc("R5 vl", 1, 2, 3'b110, 5, 1, 0);
    cyc("R6 explicit", 0, 2, 0, 5, 1, 0);
    cyc("R8 miss", 0, 0, 0, 6, 3, 0);
    // R10: fp flag ignored
    cyc("R10 fp", 0, 0, 0, 5, 0, 1);
    // R3: saturating length, R7: two entries same tag
    cyc("R3 sat", 1, 5, 200, 5, 0, 0);
    cyc("R3 sat", 1, 5, 65, 5, 0, 0);
    cyc("R7 dup", 1, 4, 8'h85, 5, 3, 0);
    cyc("R7 lowest", 0, 5, 0, 5, 3, 1);
    // R9: invalidate entry 0 with tag kept
    cyc("R9 clear", 1, 0, 8'h05, 5, 2, 0);
    cyc("R9 fallthrough", 0, 0, 0, 5, 2, 0);
    // R6: width field with explicit bit clear uses default
    cyc("R6 dflt", 1, 6, 3'b011, 5, 1, 0);
    cyc("R6 dflt", 0, 6, 0, 5, 0, 0);
    // R2: reserved field
    cyc("R2 rsvd", 1, 3, 8'hff, 5, 0, 0);
    cyc("R2 rsvd", 1, 7, 8'hff, 5, 0, 0);
    cyc("R2 rsvd", 0, 7, 0, 5, 0, 0);
    cyc("R3 exact", 1, 1, 64, 5, 0, 0);
    cyc("R3 exact", 1, 1, 0, 5, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 2000; k++) begin
      int r = int'($urandom);
      cyc("R4 random", r[0], (r >> 1) & 7, (r >> 4) & 8'h9f | ((r >> 12) & 8'h60),
          (r >> 20) & 7, (r >> 23) & 3, r[25]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R4: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule